// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block produces four new 32-bit words of the SM3 message schedule per operation. It takes three 128-bit operand vectors, each holding four 32-bit lanes, and a one-bit operation select. The select picks one of two steps. The preliminary step combines older schedule words and passes the result through the P1 permutation. The final step merges those temporaries with further schedule words to give the expanded words W16..W19. Software or a surrounding engine calls the preliminary step first and feeds its result, as the first operand, into the final step.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream. A single output register sits between them. An input beat is accepted when `in_valid` and `in_ready` are both high, and its result appears on the next cycle. While the output beat waits for `out_ready`, the output holds its value and `in_ready` is low. If the output is taken in the same cycle, a new beat can enter, so the block accepts one beat per cycle when it is not stalled.

Top module: `sm3_msg_expand`

## Requirements
- R1: With `in_op` = 0 (preliminary), each result lane k in 0..2 (bits 32k+31:32k) equals P1(a_k XOR c_k XOR rotl(b_k,15)). Here rotl is a 32-bit left rotate and P1(x) = x XOR rotl(x,15) XOR rotl(x,23).
- R2: With `in_op` = 0, result lane 3 equals P1(a_3 XOR c_3). Lane 3 of `in_b` (bits 127:96) has no effect on the result.
- R3: With `in_op` = 1 (final), each result lane k in 0..2 equals rotl(b_k,7) XOR c_k XOR a_k.
- R4: With `in_op` = 1, result lane 3 equals rotl(b_3,7) XOR c_3 XOR a_3 XOR rotl(L0,6) XOR rotl(L0,15) XOR rotl(L0,30), where L0 is result lane 0 of the same operation.
- R5: An accepted beat (`in_valid` and `in_ready` high at a rising edge) makes `out_valid` high on the next cycle, carrying that beat's result.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value on the next cycle.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.
- R8: `in_ready` is high exactly when the output register is empty or is being drained (`out_ready` high). A beat sent when the output drains and no new beat is accepted leaves `out_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| in_op | input | 1 | 0 = preliminary step, 1 = final step |
| in_a | input | 128 | First operand, lane k in bits 32k+31:32k |
| in_b | input | 128 | Second operand |
| in_c | input | 128 | Third operand |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| out_data | output | 128 | Four result lanes, lane k in bits 32k+31:32k |

## Verification
The assertions assume that `rst` is high at the first clock edge and that the handshake inputs are never unknown while reset is low. They do not assume that `in_valid` stays high until it is accepted, because the block takes no commitment from an input beat it has not yet accepted. The stimulus drives every input to a defined value at the falling edge, starting in reset. It varies `in_valid` and `out_ready` pseudo-randomly, so stalls, back-to-back beats and idle drains all occur. It also asserts reset once while a result is pending. A reference model in the bench tracks the expected register contents and compares them on every cycle.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = LANE_W * LANES;

  localparam int P1_ROT_A  = 15;
  localparam int P1_ROT_B  = 23;
  localparam int PRE_ROT   = 15;
  localparam int FIN_ROT   = 7;
  localparam int MIX_ROT_A = 6;
  localparam int MIX_ROT_B = 15;
  localparam int MIX_ROT_C = 30;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic {
    OP_PRE = 1'b0,
    OP_FIN = 1'b1
  } op_e;

  function automatic lane_t rotl(input lane_t x, input int n);
    return (x << n) | (x >> (LANE_W - n));
  endfunction

  function automatic lane_t perm_p1(input lane_t x);
    return x ^ rotl(x, P1_ROT_A) ^ rotl(x, P1_ROT_B);
  endfunction
endpackage

// File: rtl/sm3x_prelim.sv
module sm3x_prelim
  import sm3x_pkg::*;
(
  input  logic [VEC_W-1:0]          a_i,
  input  logic [VEC_W-LANE_W-1:0]   b_lo_i,
  input  logic [VEC_W-1:0]          c_i,
  output logic [VEC_W-1:0]          res_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < LANES - 1) begin : g_rot
      always_comb begin
        res_o[g*LANE_W +: LANE_W] = perm_p1(a_i[g*LANE_W +: LANE_W]
                                          ^ c_i[g*LANE_W +: LANE_W]
                                          ^ rotl(b_lo_i[g*LANE_W +: LANE_W], PRE_ROT));
      end
    end else begin : g_plain
      always_comb begin
        res_o[g*LANE_W +: LANE_W] = perm_p1(a_i[g*LANE_W +: LANE_W]
                                          ^ c_i[g*LANE_W +: LANE_W]);
      end
    end
  end
endmodule

// File: rtl/sm3x_final.sv
module sm3x_final
  import sm3x_pkg::*;
(
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W-1:0] c_i,
  output logic [VEC_W-1:0] res_o
);
  logic [VEC_W-1:0] base;
  lane_t            first;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      base[g*LANE_W +: LANE_W] = rotl(b_i[g*LANE_W +: LANE_W], FIN_ROT)
                               ^ c_i[g*LANE_W +: LANE_W]
                               ^ a_i[g*LANE_W +: LANE_W];
    end
  end

  assign first = base[LANE_W-1:0];

  always_comb begin
    res_o = base;
    res_o[VEC_W-1 -: LANE_W] = base[VEC_W-1 -: LANE_W]
                             ^ rotl(first, MIX_ROT_A)
                             ^ rotl(first, MIX_ROT_B)
                             ^ rotl(first, MIX_ROT_C);
  end
endmodule

// File: rtl/sm3x_stage.sv
module sm3x_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  a_r5_accept_then_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));

  a_r8_idle_drain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
  import sm3x_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  input  logic [VEC_W-1:0]  in_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data
);
  logic [VEC_W-1:0] pre_res;
  logic [VEC_W-1:0] fin_res;
  logic [VEC_W-1:0] sel_res;

  sm3x_prelim u_prelim (
    .a_i    (in_a),
    .b_lo_i (in_b[VEC_W-LANE_W-1:0]),
    .c_i    (in_c),
    .res_o  (pre_res)
  );

  sm3x_final u_final (
    .a_i   (in_a),
    .b_i   (in_b),
    .c_i   (in_c),
    .res_o (fin_res)
  );

  always_comb begin
    if (op_e'(in_op) == OP_FIN) sel_res = fin_res;
    else                        sel_res = pre_res;
  end

  sm3x_stage #(.W(VEC_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (sel_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: tb/sm3_msg_expand_tb.sv
`timescale 1ns/1ps
module sm3_msg_expand_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, in_op, out_valid, out_ready;
  logic [127:0] in_a, in_b, in_c, out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sm3_msg_expand u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] pp(input logic [31:0] x);
    return x ^ rl(x, 15) ^ rl(x, 23);
  endfunction

  function automatic logic [127:0] model(input logic op, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [31:0] w [4];
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      if (!op) begin
        if (k < 3) w[k] = pp(a[32*k +: 32] ^ c[32*k +: 32] ^ rl(b[32*k +: 32], 15));
        else       w[k] = pp(a[96 +: 32] ^ c[96 +: 32]);
      end else begin
        w[k] = rl(b[32*k +: 32], 7) ^ c[32*k +: 32] ^ a[32*k +: 32];
      end
    end
    if (op) w[3] = w[3] ^ rl(w[0], 6) ^ rl(w[0], 15) ^ rl(w[0], 30);
    for (int k = 0; k < 4; k++) r[32*k +: 32] = w[k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference state
  bit           m_valid;
  logic [127:0] m_data;
  logic         m_op;
  bit           m_stalled;

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    rst = 1'b1; in_valid = 0; in_op = 0; in_a = '0; in_b = '0; in_c = '0; out_ready = 0;
    m_valid = 0; m_data = '0; m_op = 0; m_stalled = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", {127'b0, out_valid}, 128'b0);
    chk("R7", out_data, 128'b0);
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      // compare against reference state
      chk("R5", {127'b0, out_valid}, {127'b0, m_valid});
      chk("R8", {127'b0, in_ready}, {127'b0, (!m_valid || out_ready)});
      if (m_valid && !rst) begin
        for (int k = 0; k < 4; k++) begin
          string tag;
          if (m_stalled)     tag = "R6";
          else if (k == 3)   tag = m_op ? "R4" : "R2";
          else               tag = m_op ? "R3" : "R1";
          chk(tag, {96'b0, out_data[32*k +: 32]}, {96'b0, m_data[32*k +: 32]});
        end
      end
      if (rst) begin
        chk("R7", {127'b0, out_valid}, 128'b0);
        chk("R7", out_data, 128'b0);
      end
      // new stimulus
      rst       = (n == 3000);
      in_valid  = ($urandom % 10) < 7;
      out_ready = (n > 4500) ? 1'b1 : (($urandom % 10) < 6);
      in_op     = $urandom % 2;
      for (int k = 0; k < 4; k++) begin
        in_a[32*k +: 32] = $urandom;
        in_b[32*k +: 32] = $urandom;
        in_c[32*k +: 32] = $urandom;
      end
      if (n % 50 == 0) begin in_a = '0; in_b = '0; in_c = '0; end
      if (n % 50 == 1) begin in_a = '1; in_b = '1; in_c = '1; end
      if (n % 50 == 2) begin in_a = '0; in_c = '0; in_b = 128'h1 << 31; end
      // reference update for the coming edge
      if (rst) begin
        m_valid = 0; m_data = '0; m_stalled = 0;
      end else begin
        bit acc;
        acc = in_valid && (!m_valid || out_ready);
        m_stalled = m_valid && !out_ready;
        if (m_valid && out_ready) m_valid = 0;
        if (acc) begin
          m_valid = 1;
          m_op    = in_op;
          m_data  = model(in_op, in_a, in_b, in_c);
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule